// File: doc/BRIEF.md
# Packed Vector Integer-to-Float Converter

This unit turns the integer lanes of a 128-bit vector into IEEE single or double precision values in one registered step. A 3-bit operation code selects the form. Same-width forms handle four 32-bit words or two 64-bit longs, read as signed or unsigned. Two widening forms turn either the lower or the upper pair of signed words into two doubles. A narrowing form takes two source vectors of signed longs and packs them into one vector of four singles. The packing is fixed: the second operand fills the lower half and the first operand fills the upper half.

A 2-bit rounding input applies to every lane that cannot be represented exactly. The block reports a single inexact flag for the whole vector. The result is computed from the sampled inputs into a fresh register, so a destination that aliases a source is safe. A one-cycle valid strobe marks each new result. Between strobes the result and the flag hold their last values.

Top module: `i2f_vec_convert`

## Requirements
- R1: `outValid` is high in exactly the cycle after `inValid` was sampled high. While `inValid` is low, `result` and `inexact` hold their values.
- R2: op 0 converts each 32-bit signed word i of `srcA` to a single in 32-bit lane i. op 1 does the same with the words read as unsigned, so no output sign bit is ever set.
- R3: op 2 converts each 64-bit signed long i of `srcA` to a double in 64-bit lane i. op 3 does the same with the longs read as unsigned.
- R4: op 4 converts signed words 0 and 1 of `srcA` into doubles in lanes 0 and 1. op 5 does the same with words 2 and 3. Both forms are always exact.
- R5: op 6 converts signed long i of `srcB` to single lane i, and signed long i of `srcA` to single lane i+2.
- R6: The rounding code `rm` is 0 for nearest with ties to even, 1 for toward zero, 2 toward plus infinity and 3 toward minus infinity.
- R7: `inexact` is 1 exactly when at least one active lane lost bits in conversion.
- R8: A zero integer converts to +0.0 under every rounding mode.
- R9: op 7 is reserved. It gives an all-zero result with `inexact` clear.
- R10: While `rstN` is low, `outValid`, `result` and `inexact` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Sample the operands and operation this cycle |
| op | input | 3 | Conversion form (see R2 to R5, R9) |
| rm | input | 2 | Rounding mode (see R6) |
| srcA | input | 128 | First operand vector |
| srcB | input | 128 | Second operand vector, used only by op 6 |
| outValid | output | 1 | New result present this cycle |
| result | output | 128 | Converted vector |
| inexact | output | 1 | Some lane was rounded |

## Verification
Rounding and lane packing happen together in one conversion. In the narrowing form, one lane's long needs rounding while the other three lanes convert exactly. The flag must come from that one lane, and the rounded value must still land in the packed slot taken from the second operand. A separate test holds `inValid` high for two cycles in a row, so that a new capture coincides with the presentation of the previous result. Each of the two results is then judged in its own cycle against hand-derived bit patterns.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
  localparam int WORD_W  = 32;
  localparam int LONG_W  = 64;
  localparam int VEC_W   = 128;
  localparam int LANES   = VEC_W / WORD_W;
  localparam int SP_MAN  = 23;
  localparam int SP_EXP  = 8;
  localparam int SP_BIAS = 127;
  localparam int DP_MAN  = 52;
  localparam int DP_EXP  = 11;
  localparam int DP_BIAS = 1023;

  typedef enum logic [2:0] {
    OP_W2S_S    = 3'd0,
    OP_W2S_U    = 3'd1,
    OP_L2D_S    = 3'd2,
    OP_L2D_U    = 3'd3,
    OP_WIDE_LO  = 3'd4,
    OP_WIDE_HI  = 3'd5,
    OP_L2S_PAIR = 3'd6,
    OP_NONE     = 3'd7
  } cvtOp_e;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_ZERO      = 2'd1,
    RM_UP        = 2'd2,
    RM_DOWN      = 2'd3
  } rndMode_e;

  typedef enum logic [1:0] {
    SEL_WORD    = 2'd0,
    SEL_WORD_HI = 2'd1,
    SEL_LONG    = 2'd2,
    SEL_PAIR    = 2'd3
  } laneSel_e;

  typedef struct packed {
    logic             load;
    logic             toDouble;
    logic             isSigned;
    laneSel_e         sel;
    logic [LANES-1:0] laneMask;
  } cvtCtl_t;
endpackage

// File: rtl/i2f_lane.sv
module i2f_lane
  import i2f_pkg::*;
#(
  parameter int IN_W = 64
) (
  input  logic [IN_W-1:0]   magIn,
  input  logic              negIn,
  input  logic              toDouble,
  input  rndMode_e          rm,
  output logic [LONG_W-1:0] fpOut,
  output logic              inexact
);
  localparam int LZ_W = $clog2(IN_W);

  logic [LZ_W-1:0]   lz;
  logic [IN_W-1:0]   norm;
  logic              nonZero;
  logic [SP_MAN-1:0] fracS;
  logic [DP_MAN-1:0] fracD;
  logic              gS, sS, gD, sD;
  logic              lsb, guard, sticky, roundUp;
  logic [SP_MAN:0]   sumS;
  logic [DP_MAN:0]   sumD;
  logic              carry;
  logic [LZ_W:0]     expUnb;
  logic [SP_EXP-1:0] expS;
  logic [DP_EXP-1:0] expD;

  // position of the highest set bit; ascending scan keeps the last hit
  always_comb begin
    lz = '0;
    for (int b = 0; b < IN_W; b++) begin
      if (magIn[b]) lz = LZ_W'(IN_W - 1 - b);
    end
  end

  assign norm    = magIn << lz;
  assign nonZero = norm[IN_W-1];

  assign fracS = norm[IN_W-2 -: SP_MAN];
  assign gS    = norm[IN_W-2-SP_MAN];
  assign sS    = |norm[IN_W-3-SP_MAN:0];
  assign fracD = norm[IN_W-2 -: DP_MAN];
  assign gD    = norm[IN_W-2-DP_MAN];
  assign sD    = |norm[IN_W-3-DP_MAN:0];

  assign lsb    = toDouble ? fracD[0] : fracS[0];
  assign guard  = toDouble ? gD : gS;
  assign sticky = toDouble ? sD : sS;

  always_comb begin
    unique case (rm)
      RM_NEAR_EVEN: roundUp = guard & (sticky | lsb);
      RM_ZERO:      roundUp = 1'b0;
      RM_UP:        roundUp = ~negIn & (guard | sticky);
      default:      roundUp = negIn & (guard | sticky);
    endcase
  end

  assign sumS   = {1'b0, fracS} + (SP_MAN+1)'(roundUp);
  assign sumD   = {1'b0, fracD} + (DP_MAN+1)'(roundUp);
  assign carry  = toDouble ? sumD[DP_MAN] : sumS[SP_MAN];
  assign expUnb = (LZ_W+1)'(IN_W - 1) - {1'b0, lz} + {{LZ_W{1'b0}}, carry};
  assign expS   = SP_EXP'(SP_BIAS) + SP_EXP'(expUnb);
  assign expD   = DP_EXP'(DP_BIAS) + DP_EXP'(expUnb);

  always_comb begin
    if (!nonZero)      fpOut = '0;
    else if (toDouble) fpOut = {negIn, expD, sumD[DP_MAN-1:0]};
    else               fpOut = {{(LONG_W-WORD_W){1'b0}}, negIn, expS, sumS[SP_MAN-1:0]};
  end

  assign inexact = nonZero & (guard | sticky);
endmodule

// File: rtl/i2f_control.sv
module i2f_control
  import i2f_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  cvtOp_e  op,
  output cvtCtl_t ctl,
  output logic    outValid
);
  localparam logic [LANES-1:0] ALL_LANES = {LANES{1'b1}};
  localparam logic [LANES-1:0] LOW_PAIR  = LANES'(3);

  always_comb begin
    ctl      = '0;
    ctl.load = inValid;
    unique case (op)
      OP_W2S_S:    begin ctl.isSigned = 1'b1; ctl.sel = SEL_WORD; ctl.laneMask = ALL_LANES; end
      OP_W2S_U:    begin ctl.sel = SEL_WORD; ctl.laneMask = ALL_LANES; end
      OP_L2D_S:    begin ctl.toDouble = 1'b1; ctl.isSigned = 1'b1; ctl.sel = SEL_LONG; ctl.laneMask = LOW_PAIR; end
      OP_L2D_U:    begin ctl.toDouble = 1'b1; ctl.sel = SEL_LONG; ctl.laneMask = LOW_PAIR; end
      OP_WIDE_LO:  begin ctl.toDouble = 1'b1; ctl.isSigned = 1'b1; ctl.sel = SEL_WORD; ctl.laneMask = LOW_PAIR; end
      OP_WIDE_HI:  begin ctl.toDouble = 1'b1; ctl.isSigned = 1'b1; ctl.sel = SEL_WORD_HI; ctl.laneMask = LOW_PAIR; end
      OP_L2S_PAIR: begin ctl.isSigned = 1'b1; ctl.sel = SEL_PAIR; ctl.laneMask = ALL_LANES; end
      default:     ctl.laneMask = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/i2f_datapath.sv
module i2f_datapath
  import i2f_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cvtCtl_t          ctl,
  input  rndMode_e         rm,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  output logic [VEC_W-1:0] result,
  output logic             inexact
);
  logic [LONG_W-1:0] laneFp [LANES];
  logic [LANES-1:0]  laneInx;
  logic [VEC_W-1:0]  spVec, dpVec, nextVec;

  for (genvar i = 0; i < LANES; i++) begin : gLane
    localparam int PI = i % 2;
    logic [WORD_W-1:0] word, wordHi;
    logic [LONG_W-1:0] longA, pairSrc, raw, mag;
    logic              neg;

    assign word   = srcA[WORD_W*i +: WORD_W];
    assign wordHi = srcA[WORD_W*(PI+2) +: WORD_W];
    assign longA  = srcA[LONG_W*PI +: LONG_W];
    if (i < 2) begin : gLowHalf
      assign pairSrc = srcB[LONG_W*PI +: LONG_W];
    end else begin : gHighHalf
      assign pairSrc = srcA[LONG_W*PI +: LONG_W];
    end

    always_comb begin
      unique case (ctl.sel)
        SEL_WORD:    raw = ctl.isSigned ? {{(LONG_W-WORD_W){word[WORD_W-1]}}, word}
                                        : {{(LONG_W-WORD_W){1'b0}}, word};
        SEL_WORD_HI: raw = {{(LONG_W-WORD_W){wordHi[WORD_W-1]}}, wordHi};
        SEL_LONG:    raw = longA;
        default:     raw = pairSrc;
      endcase
      if (!ctl.laneMask[i]) raw = '0;
      neg = ctl.isSigned & raw[LONG_W-1];
      mag = neg ? (~raw + LONG_W'(1)) : raw;
    end

    i2f_lane #(.IN_W(LONG_W)) uLane (
      .magIn   (mag),
      .negIn   (neg),
      .toDouble(ctl.toDouble),
      .rm      (rm),
      .fpOut   (laneFp[i]),
      .inexact (laneInx[i])
    );
  end

  always_comb begin
    spVec = '0;
    dpVec = '0;
    for (int k = 0; k < LANES; k++) spVec[WORD_W*k +: WORD_W] = laneFp[k][WORD_W-1:0];
    for (int k = 0; k < VEC_W/LONG_W; k++) dpVec[LONG_W*k +: LONG_W] = laneFp[k];
    nextVec = ctl.toDouble ? dpVec : spVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result  <= '0;
      inexact <= 1'b0;
    end else if (ctl.load) begin
      result  <= nextVec;
      inexact <= |laneInx;
    end
  end
endmodule

// File: rtl/i2f_vec_convert.sv
module i2f_vec_convert
  import i2f_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [2:0]   op,
  input  logic [1:0]   rm,
  input  logic [127:0] srcA,
  input  logic [127:0] srcB,
  output logic         outValid,
  output logic [127:0] result,
  output logic         inexact
);
  cvtCtl_t ctl;

  i2f_control uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .op      (cvtOp_e'(op)),
    .ctl     (ctl),
    .outValid(outValid)
  );

  i2f_datapath uDp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .rm     (rndMode_e'(rm)),
    .srcA   (srcA),
    .srcB   (srcB),
    .result (result),
    .inexact(inexact)
  );
endmodule

// File: rtl/i2f_vec_convert_chk.sv
module i2f_vec_convert_chk (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic [2:0]   op,
  input logic [127:0] srcA,
  input logic [127:0] srcB,
  input logic         outValid,
  input logic [127:0] result,
  input logic         inexact
);
  AST_OUT_FOLLOWS_IN: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R1
  AST_NO_STRAY_OUT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid)); // R1
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(result) && $stable(inexact))); // R1
  AST_UNSIGNED_POSITIVE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(op) == 3'd1) |-> !(result[127] | result[95] | result[63] | result[31])); // R2
  AST_WIDEN_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && ($past(op) == 3'd4 || $past(op) == 3'd5)) |-> !inexact); // R4
  AST_ZERO_POSITIVE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(srcA) == '0 && $past(srcB) == '0) |-> (result == '0 && !inexact)); // R8
  AST_RESERVED_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(op) == 3'd7) |-> (result == '0 && !inexact)); // R9
endmodule

bind i2f_vec_convert i2f_vec_convert_chk uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .op(op), .srcA(srcA), .srcB(srcB),
  .outValid(outValid), .result(result), .inexact(inexact)
);

// File: tb/i2f_vec_convert_test.sv
module i2f_vec_convert_test;
  typedef struct packed {
    logic [3:0]   req;
    logic [2:0]   op;
    logic [1:0]   rm;
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] expRes;
    logic         expInx;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    // R2 signed words, exact
    '{4'd2, 3'd0, 2'd0, 128'h00000003_FFFFFFFF_00000002_00000001, 128'h0,
      128'h40400000_BF800000_40000000_3F800000, 1'b0},
    // R2 unsigned words, rounding to nearest
    '{4'd2, 3'd1, 2'd0, 128'h7FFFFFFF_FFFFFFFF_80000000_00000001, 128'h0,
      128'h4F000000_4F800000_4F000000_3F800000, 1'b1},
    // R6 toward zero
    '{4'd6, 3'd0, 2'd1, 128'h80000000_7FFFFFFF_01000001_00000000, 128'h0,
      128'hCF000000_4EFFFFFF_4B800000_00000000, 1'b1},
    // R6 toward plus infinity
    '{4'd6, 3'd0, 2'd2, 128'hFEFFFFFF_01000001_01000003_80000001, 128'h0,
      128'hCB800000_4B800001_4B800002_CEFFFFFF, 1'b1},
    // R6 toward minus infinity
    '{4'd6, 3'd0, 2'd3, 128'hFEFFFFFF_01000001_01000003_80000001, 128'h0,
      128'hCB800001_4B800000_4B800001_CF000000, 1'b1},
    // R6 nearest, ties to even
    '{4'd6, 3'd0, 2'd0, 128'hFEFFFFFF_01000001_01000003_80000001, 128'h0,
      128'hCB800000_4B800000_4B800002_CF000000, 1'b1},
    // R3 signed longs
    '{4'd3, 3'd2, 2'd0, 128'h7FFFFFFFFFFFFFFF_FFFFFFFFFFFFFFFF, 128'h0,
      128'h43E0000000000000_BFF0000000000000, 1'b1},
    // R3 unsigned longs
    '{4'd3, 3'd3, 2'd0, 128'h8000000000000000_FFFFFFFFFFFFFFFF, 128'h0,
      128'h43E0000000000000_43F0000000000000, 1'b1},
    // R6 toward zero on doubles
    '{4'd6, 3'd2, 2'd1, 128'h7FFFFFFFFFFFFFFF_8000000000000000, 128'h0,
      128'h43DFFFFFFFFFFFFF_C3E0000000000000, 1'b1},
    // R8 zero lane under round-down
    '{4'd8, 3'd2, 2'd3, 128'h0000000000000003_0000000000000000, 128'h0,
      128'h4008000000000000_0000000000000000, 1'b0},
    // R4 widen low
    '{4'd4, 3'd4, 2'd1, 128'h80000000_00000003_7FFFFFFF_FFFFFFFF, 128'h0,
      128'h41DFFFFFFFC00000_BFF0000000000000, 1'b0},
    // R4 widen high
    '{4'd4, 3'd5, 2'd2, 128'h80000000_00000003_7FFFFFFF_FFFFFFFF, 128'h0,
      128'hC1E0000000000000_4008000000000000, 1'b0},
    // R5 narrow pair, nearest
    '{4'd5, 3'd6, 2'd0, 128'hFFFFFFFFFFFFFFFE_0000000000000001, 128'h7FFFFFFFFFFFFFFF_0000000000000003,
      128'hC0000000_3F800000_5F000000_40400000, 1'b1},
    // R5 narrow pair, toward zero
    '{4'd5, 3'd6, 2'd1, 128'hFFFFFFFFFFFFFFFE_0000000000000001, 128'h7FFFFFFFFFFFFFFF_0000000000000003,
      128'hC0000000_3F800000_5EFFFFFF_40400000, 1'b1},
    // R9 reserved op
    '{4'd9, 3'd7, 2'd0, 128'hFFFFFFFF_FFFFFFFF_12345678_87654321, 128'hFFFFFFFFFFFFFFFF_0000000000000005,
      128'h0, 1'b0},
    // R8 all-zero unsigned words under round-down
    '{4'd8, 3'd1, 2'd3, 128'h0, 128'h0, 128'h0, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [2:0]   op = '0;
  logic [1:0]   rm = '0;
  logic [127:0] srcA = '0;
  logic [127:0] srcB = '0;
  logic         outValid;
  logic [127:0] result;
  logic         inexact;
  int           checks = 0;
  int           errors = 0;
  logic         finished = 1'b0;

  always #5 clk = ~clk;

  i2f_vec_convert uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .op(op), .rm(rm),
    .srcA(srcA), .srcB(srcB), .outValid(outValid), .result(result), .inexact(inexact)
  );

  task automatic check(input int req, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] o, input logic [1:0] r, input logic [127:0] a, input logic [127:0] b);
    op = o; rm = r; srcA = a; srcB = b; inValid = 1'b1;
  endtask

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    check(10, "reset outValid", 128'(outValid), 128'h0);
    check(10, "reset result", result, 128'h0);
    check(10, "reset inexact", 128'(inexact), 128'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(1, "idle outValid", 128'(outValid), 128'h0);

    for (int v = 0; v < NV; v++) begin
      drive(VECS[v].op, VECS[v].rm, VECS[v].a, VECS[v].b);
      @(negedge clk);
      inValid = 1'b0;
      check(1, $sformatf("vec%0d outValid", v), 128'(outValid), 128'h1);
      check(int'(VECS[v].req), $sformatf("vec%0d result", v), result, VECS[v].expRes);
      check(7, $sformatf("vec%0d inexact", v), 128'(inexact), 128'(VECS[v].expInx)); // R7
    end

    // R1 hold: inputs change without a strobe
    drive(3'd0, 2'd0, 128'h00000003_FFFFFFFF_00000002_00000001, 128'h0);
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    check(1, "hold outValid", 128'(outValid), 128'h0);
    check(1, "hold result", result, 128'h0);
    check(1, "hold inexact", 128'(inexact), 128'h0);

    // R1 back-to-back strobes, R5 narrowing then R2 words
    drive(3'd6, 2'd0, 128'hFFFFFFFFFFFFFFFE_0000000000000001, 128'h7FFFFFFFFFFFFFFF_0000000000000003);
    @(negedge clk);
    check(1, "b2b first valid", 128'(outValid), 128'h1);
    check(5, "b2b first result", result, 128'hC0000000_3F800000_5F000000_40400000);
    drive(3'd1, 2'd1, 128'h7FFFFFFF_FFFFFFFF_80000000_00000001, 128'h0);
    @(negedge clk);
    inValid = 1'b0;
    check(1, "b2b second valid", 128'(outValid), 128'h1);
    check(2, "b2b second result", result, 128'h4EFFFFFF_4F7FFFFF_4F000000_3F800000);
    check(7, "b2b second inexact", 128'(inexact), 128'h1);
    @(negedge clk);
    check(1, "b2b drop valid", 128'(outValid), 128'h0);

    // R10 reset in mid-run clears held result
    rstN = 1'b0;
    @(negedge clk);
    check(10, "mid reset result", result, 128'h0);
    check(10, "mid reset inexact", 128'(inexact), 128'h0);
    rstN = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule